// File: doc/BRIEF.md
# Counter-Masked LFSR Sequence Generator

This block produces a 5-bit pseudo-random word every clock. A maximal-length linear feedback shift register and a 5-bit binary up counter advance on the same rising edge. The output word is the bitwise XOR of the two. A bare shift register repeats after 31 states. Masking it with a free-running counter of period 32 stretches the combined pattern to 992 clocks and hides the plain shift pattern.

A synchronous reset loads a caller-supplied seed into the shift register and clears the counter. Both start advancing on the first edge after reset is released. A parameter selects XNOR feedback (the default) or XOR feedback. Each choice has a single lockup state, which the shift register could never leave. A seed equal to that state is replaced at load time with a fixed safe seed. The raw register and counter values are also driven out for observation.

Top module: `lfsr_ctr_mixer`

## Requirements
- R1: On a rising edge with `rst` high, `lfsr_o` takes the seed (after R2 substitution), `cnt_o` becomes 0, and `mix_o` equals the loaded seed.
- R2: With XNOR feedback, a seed of 5'b11111 loads `SAFE_SEED` (default 5'b10101) instead of the seed.
- R3: With XNOR feedback, each edge without reset moves the register from q to {q[3:0], ~(q[4] ^ q[1])}, so bits shift toward the MSB and the new bit enters at bit 0.
- R4: Starting from any legal seed, the register returns to its starting value after exactly 31 edges and never holds the lockup state.
- R5: The counter adds one on every edge without reset and wraps from 31 to 0.
- R6: After every edge, `mix_o` equals `lfsr_o ^ cnt_o` bit by bit. `mix_o` is a register and changes only on clock edges.
- R7: The pair (register, counter) first repeats 992 edges after it was sampled, and so does the `mix_o` sequence.
- R8: Reset is synchronous and reloads the seed on every edge while it is held. Changes on `seed_i` while reset is low have no effect on any output.
- R9: With `USE_XNOR` = 0, the feedback bit is q[4] ^ q[1], and a seed of 5'b00000 loads `SAFE_SEED`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset; loads seed and clears counter |
| seed_i | input | 5 | Seed sampled while reset is high |
| mix_o | output | 5 | Registered combined word (register XOR counter) |
| lfsr_o | output | 5 | Current shift-register state |
| cnt_o | output | 5 | Current counter value |

## Verification
The hardest points to reach are the full 992-edge repeat of the combined pattern and the lockup-seed substitution. Reaching the repeat means running a single uninterrupted stretch longer than 992 edges and recording every word. The bench then compares the word at index 992 with the word at index 0, and confirms that no earlier index matches the starting register-and-counter pair. The lockup seed only comes into play when it is applied under reset. The bench therefore loads all-ones and all-zeros seeds into two instances, one built with XNOR feedback and one with XOR feedback, and each instance sees its own lockup value replaced. A seed that changes during a held reset and again during free running checks that the seed is sampled only under reset.

// File: rtl/mixgen_pkg.sv
package mixgen_pkg;
  localparam int W = 5;
  localparam int TAP_HI = 4;
  localparam int TAP_LO = 1;
  typedef logic [W-1:0] word_t;

  function automatic word_t lock_state(input bit use_xnor);
    return use_xnor ? {W{1'b1}} : {W{1'b0}};
  endfunction

  function automatic logic fb_bit(input word_t q, input bit use_xnor);
    logic x;
    x = q[TAP_HI] ^ q[TAP_LO];
    return use_xnor ? ~x : x;
  endfunction

  function automatic word_t step_state(input word_t q, input bit use_xnor);
    return {q[W-2:0], fb_bit(q, use_xnor)};
  endfunction

  function automatic word_t clean_seed(input word_t s, input bit use_xnor, input word_t safe);
    return (s == lock_state(use_xnor)) ? safe : s;
  endfunction
endpackage

// File: rtl/mix_lfsr_core.sv
module mix_lfsr_core
  import mixgen_pkg::*;
#(
  parameter bit    USE_XNOR  = 1'b1,
  parameter word_t SAFE_SEED = 5'b10101
) (
  input  logic  clk,
  input  logic  rst,
  input  word_t seed,
  output word_t q,
  output word_t q_nxt
);
  localparam word_t LOCK = lock_state(USE_XNOR);

  word_t seed_ok;
  logic  seed_swapped;

  assign seed_ok      = clean_seed(seed, USE_XNOR, SAFE_SEED);
  assign seed_swapped = (seed == LOCK);
  assign q_nxt        = rst ? seed_ok : step_state(q, USE_XNOR);

  always_ff @(posedge clk) begin
    q <= q_nxt;
  end

  // R1 / R2: load under reset, with lockup substitution
  a_r1_seed_load: assert property (@(posedge clk) (rst && !seed_swapped) |=> q == $past(seed));
  a_r2_lock_swap: assert property (@(posedge clk) (rst && seed_swapped) |=> q == SAFE_SEED);
  // R3 / R9: shift toward MSB, feedback at bit 0
  a_r3_shift: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> q[W-1:1] == $past(q[W-2:0]));
  a_r3_feedback: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> q[0] == ($past(q[4]) ^ $past(q[1]) ^ USE_XNOR));
  // R4: never in the lockup state once running
  a_r4_no_lockup: assert property (@(posedge clk) disable iff (rst) 1'b1 |=> q != LOCK);
endmodule

// File: rtl/mix_up_counter.sv
module mix_up_counter
  import mixgen_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  output word_t cnt,
  output word_t cnt_nxt
);
  logic wrap_evt;

  assign cnt_nxt  = rst ? '0 : word_t'(cnt + 1'b1);
  assign wrap_evt = !rst && (cnt == {W{1'b1}});

  always_ff @(posedge clk) begin
    cnt <= cnt_nxt;
  end

  // R1: counter clears on reset
  a_r1_cnt_clear: assert property (@(posedge clk) rst |=> cnt == '0);
  // R5: increment by one, wrap to zero
  a_r5_count: assert property (@(posedge clk) disable iff (rst)
    !wrap_evt |=> cnt == word_t'($past(cnt) + 5'd1));
  a_r5_wrap: assert property (@(posedge clk) disable iff (rst) wrap_evt |=> cnt == '0);
endmodule

// File: rtl/mix_combiner.sv
module mix_combiner
  import mixgen_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  word_t lfsr_nxt,
  input  word_t cnt_nxt,
  input  word_t lfsr_q,
  input  word_t cnt_q,
  output word_t mix
);
  always_ff @(posedge clk) begin
    mix <= lfsr_nxt ^ cnt_nxt;
  end

  // R6: registered word matches the two registered sources after each edge
  a_r6_mix_match: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (mix ^ cnt_q) == lfsr_q);
  // R1: word after reset equals loaded seed (counter is zero)
  a_r1_mix_seed: assert property (@(posedge clk) rst |=> mix == lfsr_q);
endmodule

// File: rtl/lfsr_ctr_mixer.sv
module lfsr_ctr_mixer
  import mixgen_pkg::*;
#(
  parameter bit         USE_XNOR  = 1'b1,
  parameter logic [4:0] SAFE_SEED = 5'b10101
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [4:0] seed_i,
  output logic [4:0] mix_o,
  output logic [4:0] lfsr_o,
  output logic [4:0] cnt_o
);
  word_t lfsr_q, lfsr_nxt, cnt_q, cnt_nxt, mix_q;

  mix_lfsr_core #(.USE_XNOR(USE_XNOR), .SAFE_SEED(SAFE_SEED)) u_core (
    .clk(clk), .rst(rst), .seed(seed_i), .q(lfsr_q), .q_nxt(lfsr_nxt));

  mix_up_counter u_cnt (
    .clk(clk), .rst(rst), .cnt(cnt_q), .cnt_nxt(cnt_nxt));

  mix_combiner u_comb (
    .clk(clk), .rst(rst), .lfsr_nxt(lfsr_nxt), .cnt_nxt(cnt_nxt),
    .lfsr_q(lfsr_q), .cnt_q(cnt_q), .mix(mix_q));

  assign mix_o  = mix_q;
  assign lfsr_o = lfsr_q;
  assign cnt_o  = cnt_q;
endmodule

// File: tb/lfsr_ctr_mixer_bench.sv
`timescale 1ns/100ps
module lfsr_ctr_mixer_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [4:0] seed = 5'd0;
  logic [4:0] mix_a, lfsr_a, cnt_a, mix_b, lfsr_b, cnt_b;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  lfsr_ctr_mixer u_lfsr_ctr_mixer (.clk(clk), .rst(rst), .seed_i(seed),
    .mix_o(mix_a), .lfsr_o(lfsr_a), .cnt_o(cnt_a));
  lfsr_ctr_mixer #(.USE_XNOR(1'b0)) u_lfsr_ctr_mixer_xor (.clk(clk), .rst(rst), .seed_i(seed),
    .mix_o(mix_b), .lfsr_o(lfsr_b), .cnt_o(cnt_b));

  typedef struct {
    logic [4:0] la, lb, c;
    string tag;
    int idx;
  } exp_t;
  exp_t sb[$];

  logic [4:0] m_la, m_lb, m_c;
  logic [4:0] rec_l [0:1023];
  logic [4:0] rec_c [0:1023];
  logic [4:0] rec_m [0:1023];

  // independent model: shift left, new bit is parity of bits 4 and 1 (inverted for XNOR)
  function automatic logic [4:0] mdl_next(input logic [4:0] q, input bit xn);
    logic nb;
    nb = ^{q[4], q[1], xn};
    return {q[3:0], nb};
  endfunction

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic step(input bit r, input logic [4:0] s, input string tag, input int idx);
    exp_t e;
    @(posedge clk); #1;
    rst = r; seed = s;
    if (r) begin
      m_la = (s == 5'h1f) ? 5'b10101 : s;
      m_lb = (s == 5'h00) ? 5'b10101 : s;
      m_c  = 5'd0;
    end else begin
      m_la = mdl_next(m_la, 1'b1);
      m_lb = mdl_next(m_lb, 1'b0);
      m_c  = m_c + 5'd1;
    end
    e.la = m_la; e.lb = m_lb; e.c = m_c; e.tag = tag; e.idx = idx;
    #2;
    sb.push_back(e);
  endtask

  // monitor: pops one expected item per edge, samples 2 ns after the edge
  initial begin
    forever begin
      @(posedge clk); #2;
      if (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        chk(lfsr_a == e.la, e.tag, "lfsr xnor (R3)", lfsr_a, e.la);
        chk(cnt_a == e.c, e.tag, "counter (R5)", cnt_a, e.c);
        chk(mix_a == (e.la ^ e.c), e.tag, "mix xnor (R6)", mix_a, e.la ^ e.c);
        chk(lfsr_b == e.lb && mix_b == (e.lb ^ e.c), "R9", "xor instance lfsr/mix",
            {lfsr_b, mix_b}, {e.lb, e.lb ^ e.c});
        if (e.idx >= 0) begin
          rec_l[e.idx] = lfsr_a; rec_c[e.idx] = cnt_a; rec_m[e.idx] = mix_a;
        end
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    bit ok;
    // R8 / R1: held reset, seed changes; last seed is loaded
    step(1'b1, 5'h03, "R8", -1);
    step(1'b1, 5'h07, "R8", -1);
    step(1'b1, 5'h09, "R1", -1);
    for (int i = 0; i < 40; i++) step(1'b0, 5'h09, "R3", -1);
    // R8: seed changes with reset low are ignored
    for (int i = 0; i < 6; i++) step(1'b0, 5'(i * 7), "R8", -1);
    // R2: lockup seed for XNOR; R9: same seed legal for XOR instance
    step(1'b1, 5'h1f, "R2", -1);
    for (int i = 0; i < 10; i++) step(1'b0, 5'h1f, "R2", -1);
    // R9: all-zero seed is lockup for XOR, legal for XNOR
    step(1'b1, 5'h00, "R9", -1);
    for (int i = 0; i < 10; i++) step(1'b0, 5'h00, "R9", -1);
    // R5: counter wrap covered in long run; R4 / R7: period
    step(1'b1, 5'h0b, "R1", -1);
    for (int i = 0; i < 993; i++) step(1'b0, 5'h0b, "R7", i);
    @(posedge clk); @(posedge clk); @(posedge clk); #3;

    chk(rec_l[31] == rec_l[0], "R4", "lfsr repeats at 31", rec_l[31], rec_l[0]);
    ok = 1'b1;
    for (int j = 1; j < 31; j++) if (rec_l[j] == rec_l[0]) ok = 1'b0;
    chk(ok, "R4", "lfsr no early repeat", ok, 1);
    ok = 1'b1;
    for (int j = 0; j < 993; j++) if (rec_l[j] == 5'h1f) ok = 1'b0;
    chk(ok, "R4", "no lockup state visited", ok, 1);
    chk(rec_m[992] == rec_m[0] && rec_c[992] == rec_c[0], "R7", "combined repeats at 992",
        {rec_m[992], rec_c[992]}, {rec_m[0], rec_c[0]});
    ok = 1'b1;
    for (int j = 1; j < 992; j++)
      if (rec_l[j] == rec_l[0] && rec_c[j] == rec_c[0]) ok = 1'b0;
    chk(ok, "R7", "no earlier combined repeat", ok, 1);
    ok = 1'b0;
    for (int j = 1; j < 993; j++) if (rec_c[j] == 5'd0 && rec_c[j-1] == 5'd31) ok = 1'b1;
    chk(ok, "R5", "counter wrap 31 to 0 seen", ok, 1);
    finish_run();
  end
endmodule